// File: doc/BRIEF.md
# Scan Test Sequencer

This block runs a complete structural test on a multiplexed-input scan chain of configurable length. Once started, it first exercises the chain as a plain shift register with a repeating flush pattern and compares what returns at the scan output against what it sent. It then walks through a caller-supplied number of test vectors. For each vector it loads the chain state, holds the primary-input word, and spends exactly one clock with scan-enable low so that the flip-flops capture the functional response. It then unloads that response while loading the next vector's state on the same clocks.

The chain and the logic under test sit outside the block and share its clock. The vector source is an indexed port: the block presents a vector index and reads back the chain state and the primary-input word for that index. Captured primary outputs and unloaded scan bits come out on two strobed response ports. Because unloading overlaps loading, the length of a run depends only on the vector count and the chain length. When several chains share one scan-enable, the chain length parameter is set to the longest of them.

Top module: `scan_test_seq`

## Requirements
- R1: `scan_en` is low whenever `busy` is low, and high in every busy cycle except the capture cycles.
- R2: The flush phase lasts CHAIN_LEN+4 cycles with `scan_en` high, and `scan_si` carries the repeating sequence 0,0,1,1 starting at the first busy cycle; in flush cycle c with c >= CHAIN_LEN, `scan_so` must equal the value driven on `scan_si` in cycle c-CHAIN_LEN.
- R3: Vector state bit k ends up in chain position k, where position CHAIN_LEN-1 drives `scan_so` and `scan_si` feeds position 0; bit CHAIN_LEN-1 is therefore sent first and bit 0 last.
- R4: Each vector gets exactly one capture cycle, with `scan_en` low and `pi_out` equal to that vector's primary-input word, so a run of N vectors has exactly N busy cycles with `scan_en` low.
- R5: Any flush mismatch sets `chain_fail`, ends the run after the CHAIN_LEN+4 flush cycles with `done` high, and applies no vector; `chain_fail` is cleared when the next run starts.
- R6: `po_valid` is high for one cycle directly after each capture cycle, with `po_data` holding the primary outputs seen in the capture cycle.
- R7: After each capture, `so_valid` is high for CHAIN_LEN consecutive cycles, each carrying one captured chain bit on `so_bit`, position CHAIN_LEN-1 first and position 0 last.
- R8: `busy` stays high for exactly (N+2)*CHAIN_LEN + N + 4 cycles for a vector count N (including N = 0) when the flush passes; `done` then rises and stays high until the next start, and `chain_fail` is low.
- R9: The final pass after the last vector unloads for CHAIN_LEN cycles with `scan_si` held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the scan chain |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run when the block is idle |
| vec_total | input | VCNT_W | Number of vectors N, sampled at start |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | High after a run ends, until the next start |
| chain_fail | output | 1 | Flush comparison failed in the last run |
| vec_idx | output | VCNT_W | Index of the vector being fetched |
| vec_state | input | CHAIN_LEN | Chain state of vector `vec_idx` |
| vec_pi | input | PI_W | Primary-input word of vector `vec_idx` |
| scan_en | output | 1 | High: chain shifts; low: chain captures |
| scan_si | output | 1 | Serial data into the chain |
| scan_so | input | 1 | Serial data out of the chain |
| pi_out | output | PI_W | Primary-input word applied to the logic |
| po_in | input | PO_W | Primary outputs of the logic under test |
| po_valid | output | 1 | Strobe for `po_data` |
| po_data | output | PO_W | Captured primary outputs |
| so_valid | output | 1 | Strobe for `so_bit` |
| so_bit | output | 1 | One unloaded chain bit |

## Verification
The assertions take for granted that `start` is only raised while the block is idle or done, and that `vec_state` and `vec_pi` follow `vec_idx` in the same cycle and stay stable while it does not change. The bench drives `start` for one cycle only after `done`, and serves vectors from arrays indexed directly by `vec_idx`, so the port is never stale. Random vectors come from a fixed seed; directed runs cover all-zero and all-one vectors, an empty vector set, the largest vector count and a chain whose output is stuck at 0.

// File: rtl/scan_test_seq.sv
module scan_test_seq #(
  parameter int CHAIN_LEN = 8,
  parameter int PI_W      = 4,
  parameter int PO_W      = 4,
  parameter int VCNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VCNT_W-1:0] vec_total,
  output logic              busy,
  output logic              done,
  output logic              chain_fail,
  output logic [VCNT_W-1:0] vec_idx,
  input  logic [CHAIN_LEN-1:0] vec_state,
  input  logic [PI_W-1:0]   vec_pi,
  output logic              scan_en,
  output logic              scan_si,
  input  logic              scan_so,
  output logic [PI_W-1:0]   pi_out,
  input  logic [PO_W-1:0]   po_in,
  output logic              po_valid,
  output logic [PO_W-1:0]   po_data,
  output logic              so_valid,
  output logic              so_bit
);
  localparam int CW = $clog2(CHAIN_LEN + 5);
  localparam logic [CW-1:0] LEN_C   = CW'(CHAIN_LEN);
  localparam logic [CW-1:0] LAST_FL = CW'(CHAIN_LEN + 3);
  localparam logic [CW-1:0] LAST_SH = CW'(CHAIN_LEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_FLUSH, S_SHIFT, S_CAPT} st_t;

  st_t                  st;
  logic [CW-1:0]        cnt;
  logic [CHAIN_LEN-1:0] sreg;
  logic [PI_W-1:0]      pi_r;
  logic [VCNT_W-1:0]    load_idx, n_r;
  logic                 fail_acc, have_cap, loaded;

  logic [CW-1:0] lag;
  logic          mism, more;

  assign lag  = cnt - LEN_C;
  assign mism = (st == S_FLUSH) && (cnt >= LEN_C) && (scan_so != lag[1]);
  assign more = load_idx < n_r;

  assign busy    = (st != S_IDLE);
  assign scan_en = (st == S_FLUSH) || (st == S_SHIFT);
  assign scan_si = (st == S_FLUSH) ? cnt[1] : (st == S_SHIFT) ? sreg[CHAIN_LEN-1] : 1'b0;
  assign pi_out  = pi_r;
  assign vec_idx = load_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      sreg       <= '0;
      pi_r       <= '0;
      load_idx   <= '0;
      n_r        <= '0;
      fail_acc   <= 1'b0;
      have_cap   <= 1'b0;
      loaded     <= 1'b0;
      done       <= 1'b0;
      chain_fail <= 1'b0;
      po_valid   <= 1'b0;
      po_data    <= '0;
      so_valid   <= 1'b0;
      so_bit     <= 1'b0;
    end else begin
      po_valid <= 1'b0;
      so_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st         <= S_FLUSH;
          cnt        <= '0;
          done       <= 1'b0;
          chain_fail <= 1'b0;
          fail_acc   <= 1'b0;
          n_r        <= vec_total;
          load_idx   <= '0;
        end
        S_FLUSH: begin
          if (cnt == LAST_FL) begin
            if (fail_acc || mism) begin
              chain_fail <= 1'b1;
              done       <= 1'b1;
              st         <= S_IDLE;
            end else begin
              st       <= S_SHIFT;
              cnt      <= '0;
              have_cap <= 1'b0;
              loaded   <= more;
              sreg     <= more ? vec_state : '0;
              pi_r     <= more ? vec_pi : '0;
            end
          end else begin
            cnt      <= cnt + 1'b1;
            fail_acc <= fail_acc | mism;
          end
        end
        S_SHIFT: begin
          if (have_cap) begin
            so_valid <= 1'b1;
            so_bit   <= scan_so;
          end
          sreg <= sreg << 1;
          if (cnt == LAST_SH) begin
            if (loaded) begin
              st       <= S_CAPT;
              load_idx <= load_idx + 1'b1;
            end else begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          po_valid <= 1'b1;
          po_data  <= po_in;
          st       <= S_SHIFT;
          cnt      <= '0;
          have_cap <= 1'b1;
          loaded   <= more;
          sreg     <= more ? vec_state : '0;
          pi_r     <= more ? vec_pi : '0;
        end
      endcase
    end
  end

  AST_IDLE_SE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !scan_en); // R1
  AST_CAPT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scan_en) |=> scan_en); // R4
  AST_PO_AFTER_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scan_en) |=> po_valid); // R6
  AST_PO_ONLY_AFTER_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(po_valid) |-> $past(busy && !scan_en)); // R6
  AST_FAIL_NO_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
    chain_fail |-> !po_valid && !so_valid); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_PI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scan_en) |-> $stable(pi_out)); // R4
endmodule

// File: tb/sim_scan_test_seq.sv
module sim_scan_test_seq;
  localparam int L  = 8;
  localparam int PW = 4;
  localparam int OW = 4;
  localparam int VW = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [VW-1:0] vec_total = '0;
  logic busy, done, chain_fail, scan_en, scan_si, scan_so, po_valid, so_valid, so_bit;
  logic [VW-1:0] vec_idx;
  logic [L-1:0]  vec_state;
  logic [PW-1:0] vec_pi, pi_out;
  logic [OW-1:0] po_in, po_data;

  logic [L-1:0]  vs [0:15];
  logic [PW-1:0] vp [0:15];
  logic [L-1:0]  ch = '0;
  logic          broken = 1'b0;

  int checks = 0, failures = 0, cycles = 0;
  int bcyc, capt_cnt, po_cnt, bit_cnt;
  bit flush_err, run_on;
  logic [L-1:0] si_hist;

  always #10 clk = ~clk;

  scan_test_seq #(.CHAIN_LEN(L), .PI_W(PW), .PO_W(OW), .VCNT_W(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_total(vec_total),
    .busy(busy), .done(done), .chain_fail(chain_fail), .vec_idx(vec_idx),
    .vec_state(vec_state), .vec_pi(vec_pi), .scan_en(scan_en), .scan_si(scan_si),
    .scan_so(scan_so), .pi_out(pi_out), .po_in(po_in), .po_valid(po_valid),
    .po_data(po_data), .so_valid(so_valid), .so_bit(so_bit));

  function automatic logic [L-1:0] nxt_fn(logic [L-1:0] s, logic [PW-1:0] p);
    logic [L-1:0] r;
    for (int i = 0; i < L; i++) r[i] = s[(i + L - 1) % L] ^ p[i % PW];
    return r;
  endfunction

  function automatic logic [OW-1:0] po_fn(logic [L-1:0] s, logic [PW-1:0] p);
    logic [OW-1:0] r;
    for (int i = 0; i < OW; i++) r[i] = s[i] ^ s[L-1-i] ^ p[i % PW];
    return r;
  endfunction

  assign vec_state = vs[vec_idx];
  assign vec_pi    = vp[vec_idx];
  assign scan_so   = broken ? 1'b0 : ch[L-1];
  assign po_in     = po_fn(ch, pi_out);

  always_ff @(posedge clk)
    if (scan_en) ch <= {ch[L-2:0], scan_si};
    else         ch <= nxt_fn(ch, pi_out);

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    if (run_on) begin
      if (busy) begin
        if (bcyc < L + 4 && (!scan_en || scan_si !== ((bcyc % 4) >= 2))) flush_err = 1;
        if (!scan_en) capt_cnt++;
        si_hist = {si_hist[L-2:0], scan_si};
        bcyc++;
      end else if (scan_en) begin
        chk(0, "R1 scan_en while idle", 1, 0);
      end
      if (po_valid) begin
        if (po_cnt < 16)
          chk(po_data == po_fn(vs[po_cnt], vp[po_cnt]), "R6/R3 po_data",
              int'(po_data), int'(po_fn(vs[po_cnt], vp[po_cnt])));
        po_cnt++;
      end
      if (so_valid) begin
        int k, j;
        logic [L-1:0] c;
        k = bit_cnt / L;
        j = bit_cnt % L;
        if (k < 16) begin
          c = nxt_fn(vs[k], vp[k]);
          chk(so_bit == c[L-1-j], "R7 unload bit", int'(so_bit), int'(c[L-1-j]));
        end
        bit_cnt++;
      end
    end
  end

  task automatic run(int n, bit brk);
    int w;
    vec_total = VW'(n);
    broken    = brk;
    bcyc = 0; capt_cnt = 0; po_cnt = 0; bit_cnt = 0; flush_err = 0; si_hist = '1;
    run_on = 1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    @(negedge clk);
    @(negedge clk);
    run_on = 0;
    chk(done == 1'b1, "R8 done held", int'(done), 1);
    chk(!busy && !scan_en, "R1 idle scan_en low", int'(scan_en), 0);
    if (brk) begin
      chk(chain_fail == 1'b1, "R5 chain_fail set", int'(chain_fail), 1);
      chk(bcyc == L + 4, "R5 busy cycles on abort", bcyc, L + 4);
      chk(po_cnt == 0 && bit_cnt == 0, "R5 no vectors applied", po_cnt + bit_cnt, 0);
    end else begin
      chk(chain_fail == 1'b0, "R8 chain_fail clear", int'(chain_fail), 0);
      chk(bcyc == (n + 2) * L + n + 4, "R8 busy cycle count", bcyc, (n + 2) * L + n + 4);
      chk(!flush_err, "R2 flush pattern and scan_en", int'(flush_err), 0);
      chk(capt_cnt == n, "R4 capture cycles", capt_cnt, n);
      chk(po_cnt == n, "R6 po_valid count", po_cnt, n);
      chk(bit_cnt == n * L, "R7 unloaded bits", bit_cnt, n * L);
      chk(si_hist == '0, "R9 final pass scan_si zero", int'(si_hist), 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5CA9));
    for (int i = 0; i < 16; i++) begin vs[i] = '0; vp[i] = '0; end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !chain_fail && !scan_en && !po_valid && !so_valid,
        "R1 reset state", int'({busy, done, chain_fail, scan_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(1, 0);
    for (int i = 0; i < 16; i++) begin vs[i] = '1; vp[i] = '1; end
    run(2, 0);
    run(0, 0);
    for (int i = 0; i < 16; i++) begin vs[i] = L'($urandom); vp[i] = PW'($urandom); end
    run(6, 0);
    run(0, 1);
    for (int i = 0; i < 16; i++) begin vs[i] = L'($urandom); vp[i] = PW'($urandom); end
    run(15, 0);
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 16; i++) begin vs[i] = L'($urandom); vp[i] = PW'($urandom); end
      run(1 + int'($urandom % 15), 0);
    end
    run(3, 1);
    run(3, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule